// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the host-visible register file for a two-channel IDE bus-master DMA engine. It occupies one 16-byte I/O window and decodes accesses from a simple register bus. Each access carries an address, a write enable, write data and a size code. Read data is combinational from the address and size. Each channel owns an 8-byte slice of the window. The slice holds a command byte, a status byte and a 32-bit descriptor-table base.

Toward the DMA engine, the block drives a per-channel run level, a transfer direction, a one-cycle start strobe and the descriptor base. From the engine it takes a busy level and single-cycle error and interrupt events. These events latch into status bits that software clears by writing one. The data mover, descriptor walking and drive protocol lie outside this block.

Top module: `bmdma_regwin`

## Requirements
- R1: After a synchronous active-low reset, every command, status and descriptor register reads zero, and no start strobe is issued.
- R2: Channel n occupies window offsets n*8 to n*8+7. Offset 0 of a channel is the command byte, offset 2 is the status byte, and offsets 4 to 7 hold the descriptor base, least significant byte at offset 4.
- R3: Size code 0 is one byte, code 1 is two bytes, and codes 2 and 3 are four bytes. A read at channel offsets 0 to 3 whose size is not one byte returns all ones across the requested width: 0x0000FFFF for two bytes, 0xFFFFFFFF for four.
- R4: A write at channel offsets 0 to 3 whose size is not one byte changes nothing.
- R5: A one-byte read at channel offset 1 or 3 returns 0x000000FF. A write there changes nothing.
- R6: Command bit 0 is run and bit 3 is direction, where 1 means toward memory. Both drive the matching outputs. All other command bits read 0.
- R7: A start strobe is high for exactly the one cycle after a command write that takes run from 0 to 1. Rewriting run as 1 while it is already 1 gives no strobe.
- R8: Status bit 0 reads the engine busy input for that channel, and writes do not affect it.
- R9: Status bit 1 (error) and bit 2 (interrupt) are set by one-cycle engine events. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R10: Status bits 5 and 6 are plain read/write. Status bits 3, 4 and 7 read 0.
- R11: The descriptor base accepts one-, two- and four-byte accesses on byte lanes. Bits 1:0 always read zero, and the value appears on the descriptor output.
- R12: A write to one channel leaves the other channel's registers and outputs unchanged, and so does an event on one channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte offset within the window |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data, first byte in lane 0 |
| bus_rdata | output | 32 | Read data for the current address and size |
| eng_busy | input | NUM_CH | Engine busy level per channel |
| eng_err | input | NUM_CH | One-cycle error event per channel |
| eng_irq | input | NUM_CH | One-cycle interrupt event per channel |
| dma_start | output | NUM_CH | One-cycle start strobe per channel |
| dma_run | output | NUM_CH | Run bit per channel |
| dma_to_mem | output | NUM_CH | Direction bit per channel |
| desc_base | output | NUM_CH*32 | Descriptor base per channel, channel 0 in the low word |

## Verification
The hardest situation to reach is a clearing write to status that lands in the same cycle as an engine event on the same bit. The bench drives the status write and the interrupt event from one task, so both hit the same clock edge. It then reads the bit back. Start strobes are counted on every falling edge, so a missing, doubled or spurious strobe shows up as a wrong count. The bench also performs wide and misaligned accesses in both halves of each channel slice.

// File: rtl/bmdma_pkg.sv
// Package: shared constants and types for the bus-master DMA register window.
// Assumes byte-lane little-endian data and a channel slice of 8 bytes.
package bmdma_pkg;

    localparam int SLICE_BITS = 3;

    // Access size codes on the host bus
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    // Register offsets inside a channel slice
    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd2;

    // Command bit positions
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;

    // Status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_CAPA = 5;
    localparam int ST_CAPB = 6;

    // Per-channel write controls produced by the decoder
    typedef struct packed {
        logic       cmd_we;
        logic       stat_we;
        logic [3:0] desc_we;
    } chan_wr_t;

endpackage

// File: rtl/bmdma_decode.sv
// Module: write decoder. Turns one host write into per-channel enables.
// Command and status take byte-wide writes only, and offsets 1 and 3 take none.
// The descriptor half takes byte lanes that are shifted to the register position.
// Assumes ADDR_W = log2(NUM_CH) + 3.
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr,
    input  logic [1:0]               size,
    input  logic [31:0]              wdata,
    output chan_wr_t [NUM_CH-1:0]    wr_ctl,
    output logic [31:0]              desc_wdata
);

    localparam int CH_W = ADDR_W - SLICE_BITS;

    logic [CH_W-1:0] ch;
    logic [2:0]      off;
    logic [3:0]      size_mask;
    logic [3:0]      lane_mask;
    logic            byte_acc;

    // Split the address and build the lane mask for the descriptor half
    always_comb begin
        ch        = addr[ADDR_W-1:SLICE_BITS];
        off       = addr[SLICE_BITS-1:0];
        byte_acc  = (size == SZ_BYTE);
        case (size)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_HALF: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
        lane_mask  = size_mask << off[1:0];
        desc_wdata = wdata << {off[1:0], 3'b000};
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Channel select for this write
        assign hit = wr && (ch == CH_W'(c));
        assign wr_ctl[c].cmd_we  = hit && !off[2] && byte_acc && (off[1:0] == OFF_CMD);
        assign wr_ctl[c].stat_we = hit && !off[2] && byte_acc && (off[1:0] == OFF_STAT);
        assign wr_ctl[c].desc_we = (hit && off[2]) ? lane_mask : 4'b0000;
    end

endmodule

// File: rtl/bmdma_chan.sv
// Module: register state of one DMA channel: command, status and descriptor base.
// Assumes write enables arrive already decoded and the event inputs are one-cycle pulses.
// An event takes priority over a clearing write in the same cycle.
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  chan_wr_t    wr_ctl,
    input  logic [7:0]  wbyte,
    input  logic [31:0] desc_wdata,
    input  logic        eng_busy,
    input  logic        eng_err,
    input  logic        eng_irq,
    output logic [7:0]  cmd_q,
    output logic [7:0]  stat_q,
    output logic [31:0] desc_q,
    output logic        run,
    output logic        to_mem,
    output logic        start
);

    logic        run_q, dir_q, start_q;
    logic        err_q, irq_q;
    logic [1:0]  cap_q;
    logic [31:0] desc_r, desc_next;
    logic        wbyte_unused;

    assign wbyte_unused = wbyte[7] ^ wbyte[4];

    // Command register and start strobe on a 0->1 run transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            dir_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= wr_ctl.cmd_we && wbyte[CMD_RUN] && !run_q;
            if (wr_ctl.cmd_we) begin
                run_q <= wbyte[CMD_RUN];
                dir_q <= wbyte[CMD_DIR];
            end
        end
    end

    // Status: sticky event bits with write-one-to-clear, capability bits read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b00;
        end else begin
            err_q <= eng_err || (err_q && !(wr_ctl.stat_we && wbyte[ST_ERR]));
            irq_q <= eng_irq || (irq_q && !(wr_ctl.stat_we && wbyte[ST_IRQ]));
            if (wr_ctl.stat_we) begin
                cap_q <= {wbyte[ST_CAPB], wbyte[ST_CAPA]};
            end
        end
    end

    // Lane merge for the descriptor base, keeping the alignment bits at zero
    always_comb begin
        desc_next = desc_r;
        for (int k = 0; k < 4; k++) begin
            if (wr_ctl.desc_we[k]) begin
                desc_next[8*k +: 8] = desc_wdata[8*k +: 8];
            end
        end
        desc_next[1:0] = 2'b00;
    end

    // Descriptor base register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_r <= '0;
        end else begin
            desc_r <= desc_next;
        end
    end

    // Assemble readable views and engine-facing outputs
    always_comb begin
        cmd_q           = '0;
        cmd_q[CMD_RUN]  = run_q;
        cmd_q[CMD_DIR]  = dir_q;
        stat_q          = '0;
        stat_q[ST_BUSY] = eng_busy;
        stat_q[ST_ERR]  = err_q;
        stat_q[ST_IRQ]  = irq_q;
        stat_q[ST_CAPA] = cap_q[0];
        stat_q[ST_CAPB] = cap_q[1];
    end

    assign desc_q = desc_r;
    assign run    = run_q;
    assign to_mem = dir_q;
    assign start  = start_q;

endmodule

// File: rtl/bmdma_rdmux.sv
// Module: combinational read path for the register window.
// In the command/status half, a wide access reads all ones across its width,
// and offsets 1 and 3 read 0xFF. The descriptor half reads byte lanes masked to the size.
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [1:0]                    size,
    input  logic [NUM_CH-1:0][7:0]        cmd_q,
    input  logic [NUM_CH-1:0][7:0]        stat_q,
    input  logic [NUM_CH-1:0][31:0]       desc_q,
    output logic [31:0]                   rdata
);

    localparam int CH_W = ADDR_W - SLICE_BITS;

    logic [CH_W-1:0] ch;
    logic [2:0]      off;
    logic [31:0]     width_mask;
    logic [31:0]     desc_sh;

    // Select the register and shape the data to the access width
    always_comb begin
        ch  = addr[ADDR_W-1:SLICE_BITS];
        off = addr[SLICE_BITS-1:0];
        case (size)
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_HALF: width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
        desc_sh = desc_q[ch] >> {off[1:0], 3'b000};
        if (off[2]) begin
            rdata = desc_sh & width_mask;
        end else if (size != SZ_BYTE) begin
            rdata = width_mask;
        end else begin
            case (off[1:0])
                OFF_CMD:  rdata = {24'h0, cmd_q[ch]};
                OFF_STAT: rdata = {24'h0, stat_q[ch]};
                default:  rdata = 32'h0000_00FF;
            endcase
        end
    end

endmodule

// File: rtl/bmdma_regwin.sv
// Module: top of the bus-master DMA register window.
// Holds NUM_CH channel slices of 8 bytes each, a write decoder and a read mux.
// Assumes NUM_CH is a power of two and at least 2.
module bmdma_regwin
    import bmdma_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH) + SLICE_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_CH-1:0]     eng_busy,
    input  logic [NUM_CH-1:0]     eng_err,
    input  logic [NUM_CH-1:0]     eng_irq,
    output logic [NUM_CH-1:0]     dma_start,
    output logic [NUM_CH-1:0]     dma_run,
    output logic [NUM_CH-1:0]     dma_to_mem,
    output logic [NUM_CH*32-1:0]  desc_base
);

    chan_wr_t [NUM_CH-1:0]        wr_ctl;
    logic [31:0]                  desc_wdata;
    logic [NUM_CH-1:0][7:0]       ch_cmd;
    logic [NUM_CH-1:0][7:0]       ch_stat;
    logic [NUM_CH-1:0][31:0]      ch_desc;

    bmdma_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .size       (bus_size),
        .wdata      (bus_wdata),
        .wr_ctl     (wr_ctl),
        .desc_wdata (desc_wdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        bmdma_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctl     (wr_ctl[c]),
            .wbyte      (bus_wdata[7:0]),
            .desc_wdata (desc_wdata),
            .eng_busy   (eng_busy[c]),
            .eng_err    (eng_err[c]),
            .eng_irq    (eng_irq[c]),
            .cmd_q      (ch_cmd[c]),
            .stat_q     (ch_stat[c]),
            .desc_q     (ch_desc[c]),
            .run        (dma_run[c]),
            .to_mem     (dma_to_mem[c]),
            .start      (dma_start[c])
        );
        assign desc_base[c*32 +: 32] = ch_desc[c];
    end

    bmdma_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rdmux (
        .addr   (bus_addr),
        .size   (bus_size),
        .cmd_q  (ch_cmd),
        .stat_q (ch_stat),
        .desc_q (ch_desc),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/bmdma_regwin_chk.sv
// Module: assertion checker for bmdma_regwin, attached by bind below.
// Observes ports and the per-channel status vector only.
module bmdma_regwin_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic [1:0]            bus_size,
    input logic [NUM_CH-1:0]     eng_err,
    input logic [NUM_CH-1:0]     eng_irq,
    input logic [NUM_CH-1:0]     dma_start,
    input logic [NUM_CH-1:0]     dma_run,
    input logic [NUM_CH-1:0]     dma_to_mem,
    input logic [NUM_CH*32-1:0]  desc_base,
    input logic [NUM_CH-1:0][7:0] ch_stat
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic wide_ctl_wr;
        assign wide_ctl_wr = bus_wr && (bus_size != 2'd0) && !bus_addr[2]
                             && (bus_addr[ADDR_W-1:3] == (ADDR_W-3)'(c));

        // R1: reset leaves run low and issues no strobe
        assert_reset_clear_R1: assert property (@(posedge clk)
            !rst_n |=> (!dma_run[c] && !dma_start[c]));

        // R7: the strobe lasts a single cycle
        assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |=> !dma_start[c]);

        // R7: a strobe only accompanies a running channel
        assert_start_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
            dma_start[c] |-> dma_run[c]);

        // R4: wide writes to the control half leave command state untouched
        assert_wide_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wide_ctl_wr |=> ($stable(dma_run[c]) && $stable(dma_to_mem[c])));

        // R9: an error event is visible in status the next cycle
        assert_err_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err[c] |=> ch_stat[c][1]);

        // R9: an interrupt event is visible in status the next cycle
        assert_irq_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
            eng_irq[c] |=> ch_stat[c][2]);

        // R11: descriptor base stays 4-byte aligned
        assert_desc_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
            desc_base[c*32 +: 2] == 2'b00);
    end

endmodule

bind bmdma_regwin bmdma_regwin_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .eng_err    (eng_err),
    .eng_irq    (eng_irq),
    .dma_start  (dma_start),
    .dma_run    (dma_run),
    .dma_to_mem (dma_to_mem),
    .desc_base  (desc_base),
    .ch_stat    (ch_stat)
);

// File: tb/bmdma_regwin_tb.sv
// Scoreboard bench for bmdma_regwin: driver tasks queue expected read data,
// a monitor pops and compares on the falling edge.
module bmdma_regwin_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  eng_busy = '0, eng_err = '0, eng_irq = '0;
    logic [1:0]  dma_start, dma_run, dma_to_mem;
    logic [63:0] desc_base;

    int checks = 0;
    int fails = 0;
    int start_cnt0 = 0;
    int start_cnt1 = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    bmdma_regwin u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_err(eng_err), .eng_irq(eng_irq),
        .dma_start(dma_start), .dma_run(dma_run), .dma_to_mem(dma_to_mem),
        .desc_base(desc_base)
    );

    // Monitor: compare read data and count start strobes
    always @(negedge clk) begin
        if (dma_start[0]) start_cnt0++;
        if (dma_start[1]) start_cnt1++;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a; bus_size = s; bus_wr = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr_ev(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d,
                         input logic [1:0] er, input logic [1:0] ir);
        @(posedge clk); #1;
        bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
        eng_err = er; eng_irq = ir;
        @(posedge clk); #1;
        bus_wr = 1'b0; eng_err = '0; eng_irq = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        wr_ev(a, s, d, 2'b00, 2'b00);
    endtask

    task automatic ev(input logic [1:0] er, input logic [1:0] ir);
        @(posedge clk); #1;
        eng_err = er; eng_irq = ir;
        @(posedge clk); #1;
        eng_err = '0; eng_irq = '0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, 2'd0, 32'h0, "R1 cmd0");
        rd(4'h2, 2'd0, 32'h0, "R1 stat0");
        rd(4'h4, 2'd2, 32'h0, "R1 desc0");
        rd(4'hA, 2'd0, 32'h0, "R1 stat1");
        rd(4'hC, 2'd2, 32'h0, "R1 desc1");
        settle();
        chk({30'h0, dma_run}, 32'h0, "R1 run");
        chk(start_cnt0 + start_cnt1, 0, "R1 start");

        // R3 wide reads in the control half
        rd(4'h0, 2'd1, 32'h0000_FFFF, "R3 half");
        rd(4'h2, 2'd2, 32'hFFFF_FFFF, "R3 word");
        rd(4'h9, 2'd3, 32'hFFFF_FFFF, "R3 code3 ch1");

        // R5 filler offsets
        rd(4'h1, 2'd0, 32'h0000_00FF, "R5 off1");
        rd(4'hB, 2'd0, 32'h0000_00FF, "R5 off3 ch1");
        wr(4'h1, 2'd0, 32'h0000_00FF);
        wr(4'h3, 2'd0, 32'h0000_00FF);
        rd(4'h0, 2'd0, 32'h0, "R5 cmd after filler write");
        rd(4'h2, 2'd0, 32'h0, "R5 stat after filler write");

        // R6 R7 command and strobe
        wr(4'h0, 2'd0, 32'h0000_00F9);
        settle();
        chk(start_cnt0, 1, "R7 first start");
        chk(start_cnt1, 0, "R12 no start on ch1");
        chk({30'h0, dma_run, dma_to_mem} , 32'h5, "R6 run/dir outputs");
        rd(4'h0, 2'd0, 32'h09, "R6 cmd readback");
        wr(4'h0, 2'd0, 32'h01);
        settle();
        chk(start_cnt0, 1, "R7 no restart while running");
        wr(4'h0, 2'd0, 32'h00);
        wr(4'h0, 2'd0, 32'h01);
        settle();
        chk(start_cnt0, 2, "R7 restart after stop");

        // R4 wide write to command ignored
        wr(4'h0, 2'd1, 32'h0000_0008);
        rd(4'h0, 2'd0, 32'h01, "R4 cmd after wide write");

        // R9 events, R12 independence
        ev(2'b01, 2'b10);
        rd(4'h2, 2'd0, 32'h02, "R9 err set ch0");
        rd(4'hA, 2'd0, 32'h04, "R12 irq set ch1 only");
        wr(4'h2, 2'd2, 32'h0000_00FF);
        rd(4'h2, 2'd0, 32'h02, "R4 stat after wide write");
        wr(4'h2, 2'd0, 32'h00);
        rd(4'h2, 2'd0, 32'h02, "R9 write zero keeps");
        wr(4'h2, 2'd0, 32'h02);
        rd(4'h2, 2'd0, 32'h00, "R9 w1c clears");
        ev(2'b00, 2'b01);
        wr_ev(4'h2, 2'd0, 32'h04, 2'b00, 2'b01);
        rd(4'h2, 2'd0, 32'h04, "R9 set wins over clear");

        // R10 capability bits, R8 busy mirror
        wr(4'h2, 2'd0, 32'hFF);
        rd(4'h2, 2'd0, 32'h60, "R10 cap set and events cleared");
        @(posedge clk); #1 eng_busy = 2'b01;
        rd(4'h2, 2'd0, 32'h61, "R8 busy mirror");
        wr(4'h2, 2'd0, 32'h00);
        rd(4'h2, 2'd0, 32'h01, "R8 busy not writable");
        rd(4'hA, 2'd0, 32'h04, "R12 ch1 status untouched");
        @(posedge clk); #1 eng_busy = 2'b00;

        // R11 descriptor lanes
        wr(4'h4, 2'd2, 32'h1234_5677);
        rd(4'h4, 2'd2, 32'h1234_5674, "R11 word with aligned low bits");
        rd(4'h6, 2'd1, 32'h0000_1234, "R11 upper half");
        rd(4'h5, 2'd0, 32'h0000_0056, "R11 byte lane 1");
        settle();
        chk(desc_base[31:0], 32'h1234_5674, "R11 desc output ch0");
        wr(4'h7, 2'd0, 32'h0000_00AB);
        wr(4'h4, 2'd0, 32'h0000_00FF);
        rd(4'h4, 2'd2, 32'hAB34_56FC, "R11 byte writes");
        rd(4'hC, 2'd2, 32'h0, "R12 ch1 desc untouched");
        wr(4'hE, 2'd1, 32'h0000_BEEF);
        rd(4'hC, 2'd2, 32'hBEEF_0000, "R11 half write ch1");

        // R2 channel 1 command slice
        wr(4'h8, 2'd0, 32'h01);
        settle();
        chk(start_cnt1, 1, "R2 ch1 start");
        rd(4'h8, 2'd0, 32'h01, "R2 ch1 cmd");
        rd(4'h0, 2'd0, 32'h01, "R2 ch0 cmd unchanged");
        settle();
        chk({31'h0, desc_base[32]}, 32'h0, "R2 ch1 desc alignment");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule